// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

A watchdog for a simple 32-bit register bus. Software sets a reload value and arms the timer through a control word. While it is armed, a down-counter steps on a selected tick. The counter is refreshed only when one particular key word is written to the restart register. Any other value written there does nothing. If software fails to refresh the counter in time, it reaches zero and the block sets a sticky timeout flag. When reset generation is enabled, the block also drives a reset request.

The request is a pulse whose length is set by software. While it is high, the block presents a 2-bit reset-scope code and a 25-bit per-domain mask, both captured at the moment of expiry. Downstream reset logic uses them to decide what gets reset. The count tick comes either from an internal prescaler of the bus clock or from an external 1 MHz strobe.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, these registers read 0: reload, control, timeout status and pulse width. The counter reads 0xFFFFFFFF. The domain mask reads 0x003FFFF3, which has bits 2, 3 and 22..24 clear and all other bits set. `rst_req_o` is low.
- R2: The registers sit at word index `addr_i` as follows:
  - 0: live count, read only.
  - 1: reload, 32 bits.
  - 2: restart, reads 0.
  - 3: control. Bit 0 arms counting, bit 1 enables reset, bit 4 selects the external tick, bits 6:5 hold the scope code, bit 7 is a stored boot flag. Other bits read 0.
  - 4: timeout status, bit 0.
  - 5: timeout clear, reads 0.
  - 6: pulse width, 8 bits.
  - 7: domain mask, 25 bits.
- R3: Writing exactly 0x00004755 to index 2 loads the counter from the reload register. Any other value written to index 2 leaves the counter unchanged.
- R4: With control bit 0 clear, the counter does not move. The key still loads it. Writes to index 0 are ignored.
- R5: With control bit 0 set, each selected tick decrements the counter by one.
- R6: A tick that finds the counter at zero reloads it from the reload register and sets the timeout flag.
- R7: Any write to index 5 clears the timeout flag. An expiry in the same cycle wins, and the flag stays set.
- R8: With control bit 4 set, the counter steps only on `tick_1mhz_i` pulses. With bit 4 clear, it steps once every PRESCALE clock cycles.
- R9: On expiry with control bit 1 set, `rst_req_o` is high for W clock cycles starting with the clock edge of the expiry, where W is the pulse-width register. A width of 0 gives 1 cycle.
- R10: While `rst_req_o` is high, `rst_scope_o` and `rst_domains_o` carry the scope code and mask captured at expiry. While it is low, both are 0.
- R11: With control bit 1 clear, an expiry still sets the flag but raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; `rdata_o` is 0 when low |
| addr_i | input | 3 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| tick_1mhz_i | input | 1 | External tick strobe, one clock wide |
| rst_req_o | output | 1 | Reset request pulse |
| rst_scope_o | output | 2 | Scope code: 0 SoC, 1 full chip, 2 processor, 3 reserved |
| rst_domains_o | output | 25 | Per-domain reset mask |

## Verification
A wrong count state shows up at index 0 on the next read. It also shows up as an expiry that arrives early or late by whole ticks, and the flag at index 4 and the request pulse both move with it. A corrupted pulse counter shows up as a request one or more cycles too long or too short, measured from the first edge after expiry. A stale capture of scope or mask shows up as nonzero sideband outputs while the request is low. A mis-decoded key shows up as a counter that reloads on a near-miss value, or that fails to reload on the real key.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_COUNT   = 3'd0,
    REG_RELOAD  = 3'd1,
    REG_RESTART = 3'd2,
    REG_CTRL    = 3'd3,
    REG_STATUS  = 3'd4,
    REG_CLEAR   = 3'd5,
    REG_WIDTH   = 3'd6,
    REG_MASK    = 3'd7
  } reg_e;

  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;

  typedef struct packed {
    logic       boot2;
    logic [1:0] scope;
    logic       sel_ext;
    logic       rst_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ext_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic int_tick;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign int_tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          div_q <= '0;
        else if (div_q == PW'(PRESCALE - 1)) div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign int_tick = (div_q == PW'(PRESCALE - 1));
    end
  endgenerate

  assign tick_o = sel_ext_i ? ext_tick_i : int_tick;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned MASK_W   = 25,
  parameter int unsigned PW_W     = 8,
  parameter logic [MASK_W-1:0] MASK_RST = 25'h03F_FFF3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [PW_W-1:0]   width_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              key_o,
  output logic              clr_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [PW_W-1:0]   width_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      width_q  <= '0;
      mask_q   <= MASK_RST;
    end else if (wr_en_i) begin
      unique case (reg_e'(addr_i))
        REG_RELOAD: reload_q <= wdata_i[CNT_W-1:0];
        REG_CTRL: begin
          ctrl_q.en      <= wdata_i[0];
          ctrl_q.rst_en  <= wdata_i[1];
          ctrl_q.sel_ext <= wdata_i[4];
          ctrl_q.scope   <= wdata_i[6:5];
          ctrl_q.boot2   <= wdata_i[7];
        end
        REG_WIDTH: width_q <= wdata_i[PW_W-1:0];
        REG_MASK:  mask_q  <= wdata_i[MASK_W-1:0];
        default: ;
      endcase
    end
  end

  assign key_o = wr_en_i && (reg_e'(addr_i) == REG_RESTART) && (wdata_i == RESTART_KEY);
  assign clr_o = wr_en_i && (reg_e'(addr_i) == REG_CLEAR);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (reg_e'(addr_i))
        REG_COUNT:  rdata_o = DATA_W'(count_i);
        REG_RELOAD: rdata_o = DATA_W'(reload_q);
        REG_CTRL:   rdata_o = DATA_W'({ctrl_q.boot2, ctrl_q.scope, ctrl_q.sel_ext,
                                       2'b00, ctrl_q.rst_en, ctrl_q.en});
        REG_STATUS: rdata_o = DATA_W'(flag_i);
        REG_WIDTH:  rdata_o = DATA_W'(width_q);
        REG_MASK:   rdata_o = DATA_W'(mask_q);
        default:    rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign width_o  = width_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MASK_W = 25,
  parameter int unsigned PW_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rst_en_i,
  input  logic [1:0]        scope_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [PW_W-1:0]   width_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic              tick_i,
  input  logic              key_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              flag_o,
  output logic              req_o,
  output logic [1:0]        scope_o,
  output logic [MASK_W-1:0] mask_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_q;
  logic [PW_W-1:0]   pw_q;
  logic [1:0]        lat_scope_q;
  logic [MASK_W-1:0] lat_mask_q;
  logic              step, expire;

  assign step   = en_i && tick_i && !key_i;
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (key_i)  cnt_q <= reload_i;
    else if (expire) cnt_q <= reload_i;
    else if (step)   cnt_q <= cnt_q - 1'b1;
  end

  // expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q        <= '0;
      lat_scope_q <= '0;
      lat_mask_q  <= '0;
    end else if (expire && rst_en_i) begin
      pw_q        <= (width_i == '0) ? PW_W'(1) : width_i;
      lat_scope_q <= scope_i;
      lat_mask_q  <= mask_i;
    end else if (pw_q != '0) begin
      pw_q <= pw_q - 1'b1;
      if (pw_q == PW_W'(1)) begin
        lat_scope_q <= '0;
        lat_mask_q  <= '0;
      end
    end
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
  assign req_o   = (pw_q != '0);
  assign scope_o = lat_scope_q;
  assign mask_o  = lat_mask_q;

  a_r3_key_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_i |=> cnt_q == $past(reload_i));
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !key_i) |=> $stable(cnt_q));
  a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r6_expiry_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag_q && cnt_q == $past(reload_i));
  a_r10_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (scope_o == 2'b00 && mask_o == '0));
  a_r11_req_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(rst_en_i));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned MASK_W   = 25,
  parameter int unsigned PW_W     = 8,
  parameter int unsigned PRESCALE = 4,
  parameter logic [MASK_W-1:0] MASK_RST = 25'h03F_FFF3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_1mhz_i,
  output logic              rst_req_o,
  output logic [1:0]        rst_scope_o,
  output logic [MASK_W-1:0] rst_domains_o
);
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  reload, count;
  logic [PW_W-1:0]   width;
  logic [MASK_W-1:0] mask;
  logic              key, clr, flag, tick;

  wdog_regs #(.CNT_W(CNT_W), .MASK_W(MASK_W), .PW_W(PW_W), .MASK_RST(MASK_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .count_i(count), .flag_i(flag), .ctrl_o(ctrl), .reload_o(reload),
    .width_o(width), .mask_o(mask), .key_o(key), .clr_o(clr)
  );

  wdog_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i, .rst_ni, .sel_ext_i(ctrl.sel_ext), .ext_tick_i(tick_1mhz_i), .tick_o(tick)
  );

  wdog_core #(.CNT_W(CNT_W), .MASK_W(MASK_W), .PW_W(PW_W)) u_core (
    .clk_i, .rst_ni, .en_i(ctrl.en), .rst_en_i(ctrl.rst_en), .scope_i(ctrl.scope),
    .mask_i(mask), .width_i(width), .reload_i(reload), .tick_i(tick), .key_i(key),
    .clr_i(clr), .count_o(count), .flag_o(flag), .req_o(rst_req_o),
    .scope_o(rst_scope_o), .mask_o(rst_domains_o)
  );
endmodule

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;
  localparam int PRE = 4;
  localparam int NV  = 9;

  localparam logic [2:0]  T_ADDR [NV] = '{3'd1, 3'd2, 3'd0, 3'd3, 3'd3, 3'd6, 3'd7, 3'd7, 3'd5};
  localparam logic [31:0] T_DATA [NV] = '{32'h1234_5678, 32'h0000_4755, 32'hDEAD_BEEF,
                                          32'hFFFF_FFFC, 32'h0000_000C, 32'hABCD_1234,
                                          32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] T_EXP  [NV] = '{32'h1234_5678, 32'h0, 32'h1234_5678,
                                          32'h0000_00F0, 32'h0, 32'h0000_0034,
                                          32'h01FF_FFFF, 32'h0, 32'h0};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        req;
  logic [1:0]  scope;
  logic [24:0] dom;
  int total = 0, passed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_keyed #(.PRESCALE(PRE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_1mhz_i(tick), .rst_req_o(req),
    .rst_scope_o(scope), .rst_domains_o(dom)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s actual=%h expected=%h", r, act, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic run_pulse(input string r, input logic [7:0] w, input int exp_len);
    logic [31:0] v;
    int n;
    wr(3'd6, {24'h0, w});
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h4755);
    pulse_tick();
    chk({r, " req high"}, {31'h0, req}, 32'h1);
    chk("R10 scope", {30'h0, scope}, 32'h2);
    chk("R10 mask", {7'h0, dom}, 32'h0000_0155);
    n = 0;
    while (req && n < 300) begin n++; @(negedge clk); end
    chk({r, " length"}, n, exp_len);
    chk("R10 idle sideband", {5'h0, scope, dom}, 32'h0);
    rd(3'd4, v);
    chk("R6 flag on expiry", v, 32'h1);
    wr(3'd5, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R1 reload", v, 32'h0);
    rd(3'd3, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd4, v); chk("R1 status", v, 32'h0);
    rd(3'd6, v); chk("R1 width", v, 32'h0);
    rd(3'd7, v); chk("R1 mask", v, 32'h003F_FFF3);
    chk("R1 req", {31'h0, req}, 32'h0);

    // R2 / R4 table walk
    for (int i = 0; i < NV; i++) begin
      wr(T_ADDR[i], T_DATA[i]);
      rd(T_ADDR[i], v);
      chk($sformatf("R2 vec %0d", i), v, T_EXP[i]);
    end
    repeat (20) @(negedge clk);
    rd(3'd0, v); chk("R4 disabled hold", v, 32'h1234_5678);

    // R3 key discrimination
    wr(3'd1, 32'd100); wr(3'd2, 32'h4755);
    rd(3'd0, v); chk("R3 key load", v, 32'd100);
    wr(3'd1, 32'd200);
    wr(3'd2, 32'h4756);
    rd(3'd0, v); chk("R3 near key", v, 32'd100);
    wr(3'd2, 32'h1000_4755);
    rd(3'd0, v); chk("R3 upper bits", v, 32'd100);

    // R5 / R8 external tick
    wr(3'd1, 32'd100); wr(3'd2, 32'h4755);
    wr(3'd3, 32'h11);
    repeat (3) pulse_tick();
    rd(3'd0, v); chk("R5 step by tick", v, 32'd97);
    repeat (25) @(negedge clk);
    rd(3'd0, v); chk("R8 ext only", v, 32'd97);

    // R6 expiry reload
    wr(3'd1, 32'd2); wr(3'd2, 32'h4755);
    repeat (2) pulse_tick();
    rd(3'd0, v); chk("R6 at zero", v, 32'd0);
    rd(3'd4, v); chk("R6 no flag yet", v, 32'h0);
    pulse_tick();
    rd(3'd0, v); chk("R6 reload", v, 32'd2);
    rd(3'd4, v); chk("R6 flag", v, 32'h1);
    chk("R11 no req", {31'h0, req}, 32'h0);

    // R7 clear, then expiry beats same-cycle clear
    wr(3'd5, 32'h0);
    rd(3'd4, v); chk("R7 cleared", v, 32'h0);
    wr(3'd1, 32'd0); wr(3'd2, 32'h4755);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 3'd5; wdata = '0;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(3'd4, v); chk("R7 set wins", v, 32'h1);
    wr(3'd5, 32'h0);

    // R9 / R10 reset pulse
    wr(3'd7, 32'h155);
    wr(3'd3, 32'h53);
    run_pulse("R9 w3", 8'd3, 3);
    run_pulse("R9 w0", 8'd0, 1);
    run_pulse("R9 w5", 8'd5, 5);

    // R11 reset disabled
    wr(3'd3, 32'h51);
    wr(3'd1, 32'd0); wr(3'd2, 32'h4755);
    pulse_tick();
    chk("R11 req low", {31'h0, req}, 32'h0);
    rd(3'd4, v); chk("R11 flag", v, 32'h1);
    wr(3'd5, 32'h0);

    // R8 internal prescaler period: (reload+1)*PRE cycles
    wr(3'd6, 32'd1); wr(3'd1, 32'd1);
    wr(3'd3, 32'h03);
    n = 0;
    while (!req && n < 200) begin n++; @(negedge clk); end
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 200);
    chk("R8 internal period", n, 2 * PRE);
    wr(3'd3, 32'h0);

    // R1 reset mid-operation
    wr(3'd7, 32'h0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(3'd0, v); chk("R1 count after reset", v, 32'hFFFF_FFFF);
    rd(3'd7, v); chk("R1 mask after reset", v, 32'h003F_FFF3);
    chk("R1 req after reset", {31'h0, req}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule